// File: doc/BRIEF.md
# RISC Integer Arithmetic and Logic Unit

This block is the integer execution unit of a three-operand load/store RISC pipeline. It has no internal state. It takes two 32-bit register operands, a 16-bit immediate field, a 5-bit constant shift count and an operation select. From these it produces a 32-bit result and an overflow-exception flag. The surrounding stages handle decoding, the register file and exception handling. The pipeline registers the result and the flag, and uses the flag to start a trap.

The block has two kinds of arithmetic:

- **Trapping:** signed add, subtract and add-immediate.
- **Non-trapping:** unsigned add, subtract and add-immediate. These wrap silently.

Set-less-than uses a true magnitude comparison. It does not read the sign of a difference, so it stays correct when the subtraction would overflow. The block extends the immediate itself:

- Arithmetic and compare forms sign-extend it.
- Logical forms zero-extend it.
- Load-upper-immediate places it in the upper half of the result.

OR-immediate after load-upper-immediate therefore builds any 32-bit constant.

Top module: `risc_alu`

## Requirements
- R1: ADD and SUB give A+B and A−B modulo 2^32. ADDI gives A plus the immediate modulo 2^32. For these three, `ovf_trap` is 1 exactly when the signed result does not fit in 32 bits.
- R2: ADDU, SUBU and ADDIU give the same wrapped sums and differences as their signed forms, and `ovf_trap` is always 0 for them.
- R3: `ovf_trap` is 0 for every operation other than ADD, SUB and ADDI, whatever the operands.
- R4: ADDI, ADDIU, SLTI and SLTIU use the immediate sign-extended: bit 15 is copied into bits 31:16.
- R5: ANDI, ORI and XORI use the immediate zero-extended. ORI therefore leaves bits 31:16 of A unchanged.
- R6: AND, OR and XOR combine A and B bitwise.
- R7: SLT and SLTI return 1 when A is less than the second operand as signed 32-bit values, and 0 otherwise. Bits 31:1 are always 0. The result is correct at the extremes where A minus B overflows.
- R8: SLTU and SLTIU compare A with the second operand as unsigned 32-bit values. They return 0 or 1.
- R9: LUI returns the immediate in bits 31:16 and zeros in bits 15:0. Operand A has no effect on it.
- R10: SLL, SRL and SRA shift A by the `shamt` port. Operand B has no effect on them.
- R11: SLLV, SRLV and SRAV shift A by B[4:0]. Bits 31:5 of B are ignored.
- R12: The logical shifts fill the vacated positions with zeros. The arithmetic shifts fill them with copies of A[31].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation select, an `alu_op_e` value |
| opnd_a | input | 32 | First register operand, also the value that is shifted |
| opnd_b | input | 32 | Second register operand, also the variable shift count |
| imm16 | input | 16 | Immediate field from the instruction |
| shamt | input | 5 | Constant shift count from the instruction |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow on a trapping arithmetic operation |

## Verification
The checker assumes that `op_sel` always holds a defined `alu_op_e` member. It also assumes that all inputs are settled, known values when the outputs are judged, because the unit is purely combinational. The bench meets both assumptions:

- It drives only named enum members.
- It changes every input together on one clock edge.
- It compares outputs on the opposite edge.

The overflow and comparison extremes (most positive against most negative) come from fixed table entries, not from random data, so the corner cases are hit every run.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned SH_W   = $clog2(DATA_W);

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_ADDI  = 5'd4,
        OP_ADDIU = 5'd5,
        OP_AND   = 5'd6,
        OP_OR    = 5'd7,
        OP_XOR   = 5'd8,
        OP_ANDI  = 5'd9,
        OP_ORI   = 5'd10,
        OP_XORI  = 5'd11,
        OP_SLT   = 5'd12,
        OP_SLTU  = 5'd13,
        OP_SLTI  = 5'd14,
        OP_SLTIU = 5'd15,
        OP_LUI   = 5'd16,
        OP_SLL   = 5'd17,
        OP_SRL   = 5'd18,
        OP_SRA   = 5'd19,
        OP_SLLV  = 5'd20,
        OP_SRLV  = 5'd21,
        OP_SRAV  = 5'd22
    } alu_op_e;

    typedef enum logic [2:0] {
        RS_ARITH,
        RS_AND,
        RS_OR,
        RS_XOR,
        RS_LESS,
        RS_UPPER,
        RS_SHIFT
    } res_sel_e;

    typedef enum logic [1:0] {
        SK_LEFT,
        SK_RIGHT_ZERO,
        SK_RIGHT_SIGN
    } shift_kind_e;

    typedef struct packed {
        res_sel_e    rsel;       // which unit feeds the result
        logic        b_is_imm;   // second operand comes from the immediate
        logic        imm_sext;   // sign-extend (1) or zero-extend (0)
        logic        subtract;   // adder computes A - B
        logic        trap_en;    // overflow may raise the trap
        logic        cmp_signed; // comparison treats operands as signed
        shift_kind_e shk;        // shift direction and fill
        logic        sh_var;     // count from B instead of shamt
    } alu_ctrl_t;

    function automatic alu_ctrl_t op_ctrl(alu_op_e op);
        alu_ctrl_t c;
        c = '{rsel: RS_ARITH, b_is_imm: 1'b0, imm_sext: 1'b0, subtract: 1'b0,
              trap_en: 1'b0, cmp_signed: 1'b0, shk: SK_LEFT, sh_var: 1'b0};
        case (op)
            OP_ADD:   c.trap_en = 1'b1;
            OP_ADDU:  ;
            OP_SUB:   begin c.subtract = 1'b1; c.trap_en = 1'b1; end
            OP_SUBU:  c.subtract = 1'b1;
            OP_ADDI:  begin c.b_is_imm = 1'b1; c.imm_sext = 1'b1; c.trap_en = 1'b1; end
            OP_ADDIU: begin c.b_is_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_AND:   c.rsel = RS_AND;
            OP_OR:    c.rsel = RS_OR;
            OP_XOR:   c.rsel = RS_XOR;
            OP_ANDI:  begin c.rsel = RS_AND; c.b_is_imm = 1'b1; end
            OP_ORI:   begin c.rsel = RS_OR;  c.b_is_imm = 1'b1; end
            OP_XORI:  begin c.rsel = RS_XOR; c.b_is_imm = 1'b1; end
            OP_SLT:   begin c.rsel = RS_LESS; c.cmp_signed = 1'b1; end
            OP_SLTU:  c.rsel = RS_LESS;
            OP_SLTI:  begin c.rsel = RS_LESS; c.cmp_signed = 1'b1;
                            c.b_is_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_SLTIU: begin c.rsel = RS_LESS; c.b_is_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_LUI:   c.rsel = RS_UPPER;
            OP_SLL:   c.rsel = RS_SHIFT;
            OP_SRL:   begin c.rsel = RS_SHIFT; c.shk = SK_RIGHT_ZERO; end
            OP_SRA:   begin c.rsel = RS_SHIFT; c.shk = SK_RIGHT_SIGN; end
            OP_SLLV:  begin c.rsel = RS_SHIFT; c.sh_var = 1'b1; end
            OP_SRLV:  begin c.rsel = RS_SHIFT; c.shk = SK_RIGHT_ZERO; c.sh_var = 1'b1; end
            OP_SRAV:  begin c.rsel = RS_SHIFT; c.shk = SK_RIGHT_SIGN; c.sh_var = 1'b1; end
            default:  ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_opnd.sv
module alu_opnd
    import alu_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned IW = IMM_W
) (
    input  logic [W-1:0]  reg_b,
    input  logic [IW-1:0] imm,
    input  logic          use_imm,
    input  logic          sext,
    output logic [W-1:0]  opnd_out
);
    localparam int unsigned EXT_W = W - IW;

    logic [W-1:0] imm_ext;

    always_comb begin
        imm_ext  = {{EXT_W{sext & imm[IW-1]}}, imm};
        opnd_out = use_imm ? imm_ext : reg_b;
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         subtract,
    input  logic         trap_en,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         same_sign;

    always_comb begin
        b_eff     = subtract ? ~b : b;
        sum       = a + b_eff + {{(W-1){1'b0}}, subtract};
        // Overflow: both addends share a sign that the sum does not keep
        same_sign = (a[W-1] == b_eff[W-1]);
        ovf       = trap_en & same_sign & (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
    parameter int unsigned W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    output logic         less
);
    logic mag_less;
    logic sign_diff;

    always_comb begin
        mag_less  = (a[W-2:0] < b[W-2:0]);
        sign_diff = (a[W-1] != b[W-1]);
        if (sign_diff)
            // signed: the negative one is smaller; unsigned: the one without MSB
            less = is_signed ? a[W-1] : b[W-1];
        else
            less = mag_less;
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned SW = SH_W
) (
    input  logic [W-1:0]  value,
    input  logic [SW-1:0] amount,
    input  shift_kind_e   kind,
    output logic [W-1:0]  shifted
);
    always_comb begin
        case (kind)
            SK_LEFT:       shifted = value << amount;
            SK_RIGHT_ZERO: shifted = value >> amount;
            SK_RIGHT_SIGN: shifted = W'($signed(value) >>> amount);
            default:       shifted = value << amount;
        endcase
    end
endmodule

// File: rtl/risc_alu.sv
module risc_alu
    import alu_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned IW = IMM_W,
    parameter int unsigned SW = SH_W
) (
    input  logic [4:0]    op_sel,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [IW-1:0] imm16,
    input  logic [SW-1:0] shamt,
    output logic [W-1:0]  result,
    output logic          ovf_trap
);
    localparam int unsigned LOW_W = W - IW;

    alu_ctrl_t     ctrl;
    logic [W-1:0]  b_sel;
    logic [W-1:0]  sum;
    logic          add_ovf;
    logic          less;
    logic [SW-1:0] sh_amt;
    logic [W-1:0]  sh_out;

    always_comb ctrl = op_ctrl(alu_op_e'(op_sel));

    alu_opnd #(.W(W), .IW(IW)) u_opnd (
        .reg_b    (opnd_b),
        .imm      (imm16),
        .use_imm  (ctrl.b_is_imm),
        .sext     (ctrl.imm_sext),
        .opnd_out (b_sel)
    );

    alu_addsub #(.W(W)) u_addsub (
        .a        (opnd_a),
        .b        (b_sel),
        .subtract (ctrl.subtract),
        .trap_en  (ctrl.trap_en),
        .sum      (sum),
        .ovf      (add_ovf)
    );

    alu_cmp #(.W(W)) u_cmp (
        .a         (opnd_a),
        .b         (b_sel),
        .is_signed (ctrl.cmp_signed),
        .less      (less)
    );

    always_comb sh_amt = ctrl.sh_var ? opnd_b[SW-1:0] : shamt;

    alu_shift #(.W(W), .SW(SW)) u_shift (
        .value   (opnd_a),
        .amount  (sh_amt),
        .kind    (ctrl.shk),
        .shifted (sh_out)
    );

    always_comb begin
        case (ctrl.rsel)
            RS_ARITH: result = sum;
            RS_AND:   result = opnd_a & b_sel;
            RS_OR:    result = opnd_a | b_sel;
            RS_XOR:   result = opnd_a ^ b_sel;
            RS_LESS:  result = {{(W-1){1'b0}}, less};
            RS_UPPER: result = {imm16, {LOW_W{1'b0}}};
            RS_SHIFT: result = sh_out;
            default:  result = sum;
        endcase
        ovf_trap = (ctrl.rsel == RS_ARITH) & add_ovf;
    end
endmodule

// File: rtl/risc_alu_chk.sv
module risc_alu_chk
    import alu_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned IW = IMM_W,
    parameter int unsigned SW = SH_W
) (
    input logic [4:0]    op_sel,
    input logic [W-1:0]  opnd_a,
    input logic [W-1:0]  opnd_b,
    input logic [IW-1:0] imm16,
    input logic [SW-1:0] shamt,
    input logic [W-1:0]  result,
    input logic          ovf_trap
);
    alu_op_e op;
    logic    is_trap_op;

    always_comb begin
        op         = alu_op_e'(op_sel);
        is_trap_op = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);

        AST_NO_OVERFLOW: assert (is_trap_op || !ovf_trap) else $error("flag on non-trapping op"); // R3
        AST_ADD_OVF: assert (op != OP_ADD ||
            ovf_trap == ((opnd_a[W-1] == opnd_b[W-1]) && (result[W-1] != opnd_a[W-1])))
            else $error("ADD overflow flag wrong"); // R1
        AST_ORI_UPPER: assert (op != OP_ORI ||
            (result[W-1:IW] == opnd_a[W-1:IW] && result[IW-1:0] == (opnd_a[IW-1:0] | imm16)))
            else $error("ORI result wrong"); // R5
        AST_SLT_TRUE: assert (op != OP_SLT ||
            result == {{(W-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))})
            else $error("SLT wrong"); // R7
        AST_SLTU_TRUE: assert (op != OP_SLTU ||
            result == {{(W-1){1'b0}}, (opnd_a < opnd_b)})
            else $error("SLTU wrong"); // R8
        AST_LUI_PLACE: assert (op != OP_LUI || result == {imm16, {(W-IW){1'b0}}})
            else $error("LUI wrong"); // R9
        AST_SRL_ZERO_FILL: assert (op != OP_SRL || shamt == '0 || !result[W-1])
            else $error("SRL did not zero-fill"); // R12
        AST_SRA_SIGN_FILL: assert (op != OP_SRA || result[W-1] == opnd_a[W-1])
            else $error("SRA did not sign-fill"); // R12
    end
endmodule

bind risc_alu risc_alu_chk #(.W(W), .IW(IW), .SW(SW)) u_risc_alu_chk (
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .imm16    (imm16),
    .shamt    (shamt),
    .result   (result),
    .ovf_trap (ovf_trap)
);

// File: tb/test_risc_alu.sv
`timescale 1ns/1ps
module test_risc_alu;
    import alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_sel;
    logic [31:0] opnd_a, opnd_b;
    logic [15:0] imm16;
    logic [4:0]  shamt;
    logic [31:0] result;
    logic        ovf_trap;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    risc_alu i_risc_alu (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16),
        .shamt(shamt), .result(result), .ovf_trap(ovf_trap)
    );

    typedef struct packed {
        alu_op_e     op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [4:0]  sh;
        logic [31:0] exp;
        logic        exp_ovf;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        // R1: signed add/sub/addi
        '{OP_ADD,   32'h7fffffff, 32'h00000001, 16'h0000, 5'd0, 32'h80000000, 1'b1, 4'd1},
        '{OP_ADD,   32'h00000005, 32'hfffffffd, 16'h0000, 5'd0, 32'h00000002, 1'b0, 4'd1},
        '{OP_SUB,   32'h80000000, 32'h00000001, 16'h0000, 5'd0, 32'h7fffffff, 1'b1, 4'd1},
        '{OP_SUB,   32'h00000003, 32'h00000005, 16'h0000, 5'd0, 32'hfffffffe, 1'b0, 4'd1},
        '{OP_ADDI,  32'h7ffffff0, 32'h00000000, 16'h0010, 5'd0, 32'h80000000, 1'b1, 4'd1},
        // R4: addi sign extension
        '{OP_ADDI,  32'h00000010, 32'h00000000, 16'hfff0, 5'd0, 32'h00000000, 1'b0, 4'd4},
        // R2: unsigned forms never flag
        '{OP_ADDU,  32'h7fffffff, 32'h00000001, 16'h0000, 5'd0, 32'h80000000, 1'b0, 4'd2},
        '{OP_SUBU,  32'h00000000, 32'h00000001, 16'h0000, 5'd0, 32'hffffffff, 1'b0, 4'd2},
        '{OP_ADDIU, 32'h00000000, 32'h00000000, 16'h8000, 5'd0, 32'hffff8000, 1'b0, 4'd2},
        // R5: zero-extended logical immediates
        '{OP_ANDI,  32'hffffffff, 32'h00000000, 16'h8001, 5'd0, 32'h00008001, 1'b0, 4'd5},
        '{OP_ORI,   32'h40830000, 32'h00000000, 16'hf3a4, 5'd0, 32'h4083f3a4, 1'b0, 4'd5},
        '{OP_XORI,  32'hffff0000, 32'h00000000, 16'hffff, 5'd0, 32'hffffffff, 1'b0, 4'd5},
        // R6: register logical
        '{OP_AND,   32'hf0f0f0f0, 32'hff00ff00, 16'h0000, 5'd0, 32'hf000f000, 1'b0, 4'd6},
        '{OP_OR,    32'hf0f0f0f0, 32'hff00ff00, 16'h0000, 5'd0, 32'hfff0fff0, 1'b0, 4'd6},
        '{OP_XOR,   32'hf0f0f0f0, 32'hff00ff00, 16'h0000, 5'd0, 32'h0ff00ff0, 1'b0, 4'd6},
        // R7: signed compare at overflow extremes
        '{OP_SLT,   32'h7ffffffe, 32'h80000001, 16'h0000, 5'd0, 32'h00000000, 1'b0, 4'd7},
        '{OP_SLT,   32'h80000001, 32'h7ffffffe, 16'h0000, 5'd0, 32'h00000001, 1'b0, 4'd7},
        '{OP_SLT,   32'hfffffffe, 32'hffffffff, 16'h0000, 5'd0, 32'h00000001, 1'b0, 4'd7},
        '{OP_SLTI,  32'hffffffff, 32'h00000000, 16'h0000, 5'd0, 32'h00000001, 1'b0, 4'd7},
        // R8: unsigned compare
        '{OP_SLTU,  32'h7ffffffe, 32'h80000001, 16'h0000, 5'd0, 32'h00000001, 1'b0, 4'd8},
        '{OP_SLTU,  32'hffffffff, 32'h00000001, 16'h0000, 5'd0, 32'h00000000, 1'b0, 4'd8},
        // R4: sltiu sees ffff as ffffffff
        '{OP_SLTIU, 32'h00001000, 32'h00000000, 16'hffff, 5'd0, 32'h00000001, 1'b0, 4'd4},
        // R9: lui
        '{OP_LUI,   32'h12345678, 32'h0000ffff, 16'h4083, 5'd0, 32'h40830000, 1'b0, 4'd9},
        // R10: constant shifts, B ignored
        '{OP_SLL,   32'h00000001, 32'h00000003, 16'h0000, 5'd31, 32'h80000000, 1'b0, 4'd10},
        '{OP_SRL,   32'h80000000, 32'h00000001, 16'h0000, 5'd4,  32'h08000000, 1'b0, 4'd10},
        // R12: fill behaviour
        '{OP_SRA,   32'h80000000, 32'h00000000, 16'h0000, 5'd4,  32'hf8000000, 1'b0, 4'd12},
        '{OP_SRA,   32'h40000000, 32'h00000000, 16'h0000, 5'd4,  32'h04000000, 1'b0, 4'd12},
        '{OP_SRAV,  32'h80000000, 32'h0000001f, 16'h0000, 5'd0,  32'hffffffff, 1'b0, 4'd12},
        // R11: variable shifts use B[4:0] only, shamt ignored
        '{OP_SLLV,  32'h00000003, 32'hffffffe1, 16'h0000, 5'd7,  32'h00000006, 1'b0, 4'd11},
        '{OP_SRLV,  32'hf0000000, 32'h00000024, 16'h0000, 5'd9,  32'h0f000000, 1'b0, 4'd11},
        '{OP_SRAV,  32'hf0000000, 32'h00000020, 16'h0000, 5'd3,  32'hf0000000, 1'b0, 4'd11}
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp,
                         input logic got_o, input logic exp_o);
        n_checks++;
        if (got !== exp || got_o !== exp_o) begin
            n_fail++;
            $display("FAIL R%0d: result=%h ovf=%b expected result=%h ovf=%b",
                     req, got, got_o, exp, exp_o);
        end
    endtask

    task automatic apply(input alu_op_e op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [4:0] sh);
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; imm16 = imm; shamt = sh;
        @(negedge clk);
    endtask

    initial begin
        op_sel = OP_ADD; opnd_a = '0; opnd_b = '0; imm16 = '0; shamt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset-time idle inputs: zero result, no trap (R1)
        check(1, result, 32'h0, ovf_trap, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].sh);
            check(int'(VECS[i].req), result, VECS[i].exp, ovf_trap, VECS[i].exp_ovf);
        end

        // R1: 0 - most negative overflows
        apply(OP_SUB, 32'h00000000, 32'h80000000, 16'h0, 5'd0);
        check(1, result, 32'h80000000, ovf_trap, 1'b1);

        // R3: flag stays low on every non-trapping op with overflowing operands
        for (int k = 0; k <= int'(OP_SRAV); k++) begin
            alu_op_e o;
            o = alu_op_e'(k);
            if (o != OP_ADD && o != OP_SUB && o != OP_ADDI) begin
                apply(o, 32'h7fffffff, 32'h7fffffff, 16'h7fff, 5'd1);
                n_checks++;
                if (ovf_trap !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R3: op=%0d ovf=%b expected ovf=0", k, ovf_trap);
                end
            end
        end

        // R9: LUI ignores A
        apply(OP_LUI, 32'hffffffff, 32'hffffffff, 16'h0001, 5'd31);
        check(9, result, 32'h00010000, ovf_trap, 1'b0);

        // R7: most positive vs most negative
        apply(OP_SLT, 32'h7fffffff, 32'h80000000, 16'h0, 5'd0);
        check(7, result, 32'h0, ovf_trap, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule